// File: doc/BRIEF.md
# Interrupt Pending Eligibility Mask

This block works out, for a bank of interrupts (32 by default), which ones may be forwarded to a CPU interface for priority selection. Every input is a vector with one bit per interrupt. Each interrupt keeps a pending latch. The latch is set by a rising edge on an edge-configured input or by a software set pulse, and it is cleared by a software clear pulse.

An interrupt counts as pending when its latch is set, or when it is level-configured and its input is high. A pending interrupt is eligible when it is enabled, not active, and its security group is enabled. The group comes from a group bit and a modifier bit. A global security-disable bit forces every modifier to zero. All bits are evaluated in parallel with vector operations.

The eligible mask and the per-interrupt 2-bit group class are registered. They reflect the inputs, and the latch state being written, at the previous clock edge. The latch vector is also brought out so that the set and clear behaviour can be observed.

Top module: `irq_elig_mask`

## Requirements
- R1: An interrupt is pending when its latch is set, or when its edge_cfg bit is 0 (level mode) and its irq_in bit is 1. A level-mode interrupt leaves the mask when its input falls.
- R2: A pending interrupt appears in elig_mask only when its enable bit is 1 and its active bit is 0.
- R3: When edge_cfg is 1, a 0-to-1 change of irq_in between two clock edges sets the latch. The previous input value is held in a register that resets to 0. An input held high does not set the latch again. A level-mode input never sets the latch.
- R4: When sec_dis is 1, every grpmod bit is treated as 0. Such interrupts then report class 0 and are gated by en_grp0.
- R5: Group bit 1 is gated by en_grp1ns. Group bit 0 with modifier 1 is gated by en_grp1s. Group bit 0 with modifier 0 is gated by en_grp0.
- R6: A sw_set bit sets its latch and a sw_clr bit clears it. When both are 1 in the same cycle, the latch ends up set.
- R7: grp_class[2i+1:2i] gives the class of interrupt i: 0 for group 0, 1 for secure group 1, 2 for non-secure group 1.
- R8: elig_mask and grp_class are registered. A change on any input shows at the outputs after the next rising clock edge and not before it. A latch that is set at an edge is already counted in the mask produced at that same edge.
- R9: While rst_n is low, elig_mask, grp_class and pend_latch are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N | Raw interrupt input levels |
| edge_cfg | input | N | 1 = edge-triggered, 0 = level-sensitive |
| sw_set | input | N | Software set pulse for the pending latch |
| sw_clr | input | N | Software clear pulse for the pending latch |
| enable | input | N | Per-interrupt enable |
| active | input | N | Per-interrupt active state |
| group | input | N | Group bit (1 = non-secure group 1) |
| grpmod | input | N | Group modifier bit |
| en_grp0 | input | 1 | Group 0 enable |
| en_grp1s | input | 1 | Secure group 1 enable |
| en_grp1ns | input | 1 | Non-secure group 1 enable |
| sec_dis | input | 1 | Security disable; forces modifiers to zero |
| elig_mask | output | N | Registered eligible-interrupt mask |
| grp_class | output | 2*N | Registered 2-bit class per interrupt |
| pend_latch | output | N | Pending latch state |

## Verification
On every cycle the assertions check the following. No eligible bit can be disabled or active in the cycle before. No eligible bit can belong to a class whose enable was off. The secure group 1 class never appears while security is disabled. Set pulses always leave their latch bits set, and a clear pulse alone always leaves them clear. Every newly set latch bit traces back to a set pulse or a detected edge. The bench scenarios cover what the assertions cannot. These are the exact mask values for level and edge inputs, the non-retrigger of a held input after a clear, the one-edge latency, the class encodings, and the re-gating of secure interrupts into group 0 when security is disabled.

// File: rtl/irq_elig_pkg.sv
package irq_elig_pkg;

  typedef enum logic [1:0] {
    GC_G0  = 2'd0,
    GC_S1  = 2'd1,
    GC_NS1 = 2'd2
  } grp_class_e;

  // Class of one interrupt from its group bit, modifier bit and security-disable
  function automatic grp_class_e classify(input logic grp, input logic mdf, input logic sdis);
    logic eff_mod;
    eff_mod = mdf & ~sdis;
    if (grp)          return GC_NS1;
    else if (eff_mod) return GC_S1;
    else              return GC_G0;
  endfunction

  // Whether a class is allowed through by the three global enables
  function automatic logic class_open(input grp_class_e c, input logic e0,
                                      input logic e1s, input logic e1ns);
    case (c)
      GC_NS1:  return e1ns;
      GC_S1:   return e1s;
      default: return e0;
    endcase
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] edge_cfg,
  input  logic [N-1:0] sw_set,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] latch_q,
  output logic [N-1:0] latch_nxt,
  output logic [N-1:0] edge_ev
);

  logic [N-1:0] irq_prev;
  logic [N-1:0] set_ev;

  assign edge_ev   = irq_in & ~irq_prev & edge_cfg;
  assign set_ev    = sw_set | edge_ev;
  // set dominates clear
  assign latch_nxt = set_ev | (latch_q & ~sw_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev <= '0;
      latch_q  <= '0;
    end else begin
      irq_prev <= irq_in;
      latch_q  <= latch_nxt;
    end
  end

endmodule

// File: rtl/irq_grp_gate.sv
module irq_grp_gate
  import irq_elig_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]   group,
  input  logic [N-1:0]   grpmod,
  input  logic           sec_dis,
  input  logic           en_grp0,
  input  logic           en_grp1s,
  input  logic           en_grp1ns,
  output logic [N-1:0]   grp_open,
  output logic [2*N-1:0] class_vec
);

  logic [N-1:0] eff_mod;
  logic [N-1:0] open_vec;

  // parallel gate: all bits at once
  assign eff_mod  = sec_dis ? '0 : grpmod;
  assign open_vec = ({N{en_grp1ns}} & group)
                  | ({N{en_grp1s}}  & ~group & eff_mod)
                  | ({N{en_grp0}}   & ~group & ~eff_mod);
  assign grp_open = open_vec;

  for (genvar i = 0; i < N; i++) begin : g_cls
    assign class_vec[2*i +: 2] = classify(group[i], grpmod[i], sec_dis);
  end

endmodule

// File: rtl/irq_elig_mask.sv
module irq_elig_mask #(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   irq_in,
  input  logic [N-1:0]   edge_cfg,
  input  logic [N-1:0]   sw_set,
  input  logic [N-1:0]   sw_clr,
  input  logic [N-1:0]   enable,
  input  logic [N-1:0]   active,
  input  logic [N-1:0]   group,
  input  logic [N-1:0]   grpmod,
  input  logic           en_grp0,
  input  logic           en_grp1s,
  input  logic           en_grp1ns,
  input  logic           sec_dis,
  output logic [N-1:0]   elig_mask,
  output logic [2*N-1:0] grp_class,
  output logic [N-1:0]   pend_latch
);

  localparam int CW = 2 * N;

  logic [N-1:0]  latch_q;
  logic [N-1:0]  latch_nxt;
  logic [N-1:0]  edge_ev;
  logic [N-1:0]  grp_open;
  logic [CW-1:0] class_vec;
  logic [N-1:0]  pend_now;
  logic [N-1:0]  elig_nxt;
  logic [N-1:0]  elig_q;
  logic [CW-1:0] class_q;

  irq_pend_bank #(.N(N)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .edge_cfg  (edge_cfg),
    .sw_set    (sw_set),
    .sw_clr    (sw_clr),
    .latch_q   (latch_q),
    .latch_nxt (latch_nxt),
    .edge_ev   (edge_ev)
  );

  irq_grp_gate #(.N(N)) u_gate (
    .group     (group),
    .grpmod    (grpmod),
    .sec_dis   (sec_dis),
    .en_grp0   (en_grp0),
    .en_grp1s  (en_grp1s),
    .en_grp1ns (en_grp1ns),
    .grp_open  (grp_open),
    .class_vec (class_vec)
  );

  assign pend_now = latch_nxt | (~edge_cfg & irq_in);
  assign elig_nxt = pend_now & enable & ~active & grp_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elig_q  <= '0;
      class_q <= '0;
    end else begin
      elig_q  <= elig_nxt;
      class_q <= class_vec;
    end
  end

  assign elig_mask  = elig_q;
  assign grp_class  = class_q;
  assign pend_latch = latch_q;

endmodule

// File: rtl/irq_elig_mask_chk.sv
module irq_elig_mask_chk #(
  parameter int N = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   sw_set,
  input logic [N-1:0]   sw_clr,
  input logic [N-1:0]   enable,
  input logic [N-1:0]   active,
  input logic           en_grp0,
  input logic           en_grp1s,
  input logic           en_grp1ns,
  input logic           sec_dis,
  input logic [N-1:0]   elig_mask,
  input logic [2*N-1:0] grp_class,
  input logic [N-1:0]   pend_latch,
  input logic [N-1:0]   edge_ev
);

  logic         past_ok;
  logic [N-1:0] is_g0, is_s1, is_ns1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      is_g0[i]  = (grp_class[2*i +: 2] == 2'd0);
      is_s1[i]  = (grp_class[2*i +: 2] == 2'd1);
      is_ns1[i] = (grp_class[2*i +: 2] == 2'd2);
    end
  end

  p_no_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((elig_mask & $past(active)) == '0));

  p_need_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((elig_mask & ~$past(enable)) == '0));

  p_gate_g0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ((elig_mask & is_g0) != '0)) |-> $past(en_grp0));

  p_gate_s1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ((elig_mask & is_s1) != '0)) |-> $past(en_grp1s));

  p_gate_ns1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ((elig_mask & is_ns1) != '0)) |-> $past(en_grp1ns));

  p_secdis_no_s1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(sec_dis)) |-> (is_s1 == '0));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_latch & $past(sw_set)) == $past(sw_set)));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_latch & $past(sw_clr & ~sw_set & ~edge_ev)) == '0));

  p_latch_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_latch & ~$past(pend_latch) & ~$past(sw_set | edge_ev)) == '0));

endmodule

bind irq_elig_mask irq_elig_mask_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_set     (sw_set),
  .sw_clr     (sw_clr),
  .enable     (enable),
  .active     (active),
  .en_grp0    (en_grp0),
  .en_grp1s   (en_grp1s),
  .en_grp1ns  (en_grp1ns),
  .sec_dis    (sec_dis),
  .elig_mask  (elig_mask),
  .grp_class  (grp_class),
  .pend_latch (pend_latch),
  .edge_ev    (edge_ev)
);

// File: tb/tb_irq_elig_mask.sv
module tb_irq_elig_mask;

  localparam int N = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   irq_in, edge_cfg, sw_set, sw_clr, enable, active, group, grpmod;
  logic           en_grp0, en_grp1s, en_grp1ns, sec_dis;
  logic [N-1:0]   elig_mask, pend_latch;
  logic [2*N-1:0] grp_class;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [N-1:0] mdl_latch, mdl_prev;

  always #10 clk = ~clk;

  irq_elig_mask #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_cfg(edge_cfg),
    .sw_set(sw_set), .sw_clr(sw_clr), .enable(enable), .active(active),
    .group(group), .grpmod(grpmod), .en_grp0(en_grp0), .en_grp1s(en_grp1s),
    .en_grp1ns(en_grp1ns), .sec_dis(sec_dis), .elig_mask(elig_mask),
    .grp_class(grp_class), .pend_latch(pend_latch)
  );

  task automatic chk(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock step: predict from the requirements, let one edge pass, compare
  task automatic tick(input string tag);
    logic [N-1:0]   e_latch, e_elig;
    logic [2*N-1:0] e_cls;
    for (int i = 0; i < N; i++) begin
      logic setb, pend, m;
      logic [1:0] c;
      setb = sw_set[i] || (edge_cfg[i] && irq_in[i] && !mdl_prev[i]);
      e_latch[i] = setb || (mdl_latch[i] && !sw_clr[i]);
      pend = e_latch[i] || (!edge_cfg[i] && irq_in[i]);
      m = sec_dis ? 1'b0 : grpmod[i];
      c = group[i] ? 2'd2 : (m ? 2'd1 : 2'd0);
      e_cls[2*i +: 2] = c;
      e_elig[i] = pend && enable[i] && !active[i] &&
                  ((c == 2'd2) ? en_grp1ns : (c == 2'd1) ? en_grp1s : en_grp0);
    end
    @(negedge clk);
    mdl_latch = e_latch;
    mdl_prev  = irq_in;
    chk({tag, " mask"},  {{N{1'b0}}, elig_mask},  {{N{1'b0}}, e_elig});
    chk({tag, " class"}, grp_class,                e_cls);
    chk({tag, " latch"}, {{N{1'b0}}, pend_latch}, {{N{1'b0}}, e_latch});
  endtask

  task automatic t_reset();
    rst_n = 0;
    irq_in = '0; edge_cfg = '0; sw_set = '0; sw_clr = '0; enable = '0;
    active = '0; group = '0; grpmod = '0;
    en_grp0 = 0; en_grp1s = 0; en_grp1ns = 0; sec_dis = 0;
    mdl_latch = '0; mdl_prev = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset mask",  {{N{1'b0}}, elig_mask},  '0);
    chk("R9 reset class", grp_class,                '0);
    chk("R9 reset latch", {{N{1'b0}}, pend_latch}, '0);
    rst_n = 1;
  endtask

  task automatic t_level();
    en_grp0 = 1; enable = '1; edge_cfg = '0;
    irq_in = 32'h0000_00F0;
    tick("R1 level high");
    chk("R1 level mask literal", {{N{1'b0}}, elig_mask}, 64'hF0);
    irq_in = '0;
    tick("R1 level low");
    chk("R1 level drop literal", {{N{1'b0}}, elig_mask}, 64'h0);
  endtask

  task automatic t_active_enable();
    irq_in = 32'h0000_00F0; active = 32'h30;
    tick("R2 active");
    chk("R2 active literal", {{N{1'b0}}, elig_mask}, 64'hC0);
    enable = ~32'h80;
    tick("R2 enable");
    chk("R2 enable literal", {{N{1'b0}}, elig_mask}, 64'h40);
    active = '0; enable = '1; irq_in = '0;
    tick("R2 restore");
  endtask

  task automatic t_edge();
    edge_cfg = '1; irq_in = 32'h8;
    tick("R3 rising edge");
    chk("R3 edge latch literal", {{N{1'b0}}, pend_latch}, 64'h8);
    irq_in = '0;
    tick("R3 held after fall");
    chk("R3 latched mask literal", {{N{1'b0}}, elig_mask}, 64'h8);
    irq_in = 32'h8;
    tick("R3 re-edge");
    sw_clr = 32'h8;
    tick("R6 clear");
    sw_clr = '0;
    tick("R3 no retrigger");
    chk("R3 held high stays clear", {{N{1'b0}}, pend_latch}, 64'h0);
    edge_cfg = ~32'h20; irq_in = 32'h28;
    tick("R3 level no latch");
    chk("R3 level latch literal", {{N{1'b0}}, pend_latch}, 64'h0);
    chk("R1 level in mask", {{N{1'b0}}, elig_mask}, 64'h20);
    irq_in = '0;
    tick("R3 idle");
  endtask

  task automatic t_sw();
    sw_set = 32'h101; sw_clr = 32'h100;
    tick("R6 set wins");
    chk("R6 set wins literal", {{N{1'b0}}, pend_latch}, 64'h101);
    sw_set = '0; sw_clr = 32'h1;
    tick("R6 clear one");
    chk("R6 clear literal", {{N{1'b0}}, elig_mask}, 64'h100);
    sw_clr = 32'h100;
    tick("R6 clear rest");
    sw_clr = '0;
    tick("R6 idle");
  endtask

  task automatic t_groups();
    sw_set = 32'hFFFF;
    tick("R6 load");
    sw_set = '0;
    group = 32'hFF00; grpmod = 32'h00F0;
    en_grp0 = 1; en_grp1s = 0; en_grp1ns = 0;
    tick("R5 g0 only");
    chk("R5 g0 literal", {{N{1'b0}}, elig_mask}, 64'h000F);
    chk("R7 class ns1", {62'b0, grp_class[2*9 +: 2]}, 64'd2);
    chk("R7 class s1",  {62'b0, grp_class[2*5 +: 2]}, 64'd1);
    chk("R7 class g0",  {62'b0, grp_class[2*1 +: 2]}, 64'd0);
    en_grp0 = 0; en_grp1s = 1;
    #1;
    chk("R8 no change before edge", {{N{1'b0}}, elig_mask}, 64'h000F);
    tick("R5 s1 only");
    chk("R5 s1 literal", {{N{1'b0}}, elig_mask}, 64'h00F0);
    en_grp1s = 0; en_grp1ns = 1;
    tick("R5 ns1 only");
    chk("R5 ns1 literal", {{N{1'b0}}, elig_mask}, 64'hFF00);
    en_grp1ns = 0; en_grp0 = 1; sec_dis = 1;
    tick("R4 sec_dis");
    chk("R4 sec_dis literal", {{N{1'b0}}, elig_mask}, 64'h00FF);
    chk("R4 class forced g0", {62'b0, grp_class[2*5 +: 2]}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_active_enable();
    t_edge();
    t_sw();
    t_groups();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule